// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each slot holds a virtual page number, an address-space identifier, a physical frame number, a valid flag and a wired flag. A lookup presents a page number, the identifier of the running process and the page offset. All slots are compared at once. In the same cycle the block returns a hit with the frame number and the assembled physical address, or it raises a miss. The page walk that resolves a miss is done outside the block.

Once a walk has produced a translation, it is written back through the refill port with a valid/ready handshake. A transfer happens on a rising edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low only while `flush` is high. During that time the source must hold its translation until `fill_ready` returns. If the refill's page number and identifier already sit in a slot, that slot is rewritten in place. Otherwise a round-robin victim pointer picks the next slot that is not wired. Wired slots are never replaced and never flushed. If every slot is wired, the refill is dropped and a one-cycle error flag is raised.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid: every lookup reports a miss, `fill_drop_err` is 0 and `fill_ready` is 1.
- R2: A lookup whose page number and identifier match a valid slot gives, in the same cycle, `lk_hit`=1, `lk_miss`=0, `lk_pfn` equal to the stored frame, and `lk_paddr` = {frame, `lk_off`} (frame in the upper bits). The match is combinational from the edge that wrote the slot.
- R3: A slot with a matching page number but a different identifier does not hit.
- R4: With `lk_req`=1 and no match, `lk_miss`=1 and `lk_hit`=0. With `lk_req`=0, both are 0. The two are never high together.
- R5: A refill whose page number and identifier match a valid slot overwrites that slot's frame and wired flag. No second slot is allocated, and the victim pointer does not move.
- R6: A refill of a new tag goes to the first non-wired slot found searching upward from the victim pointer, wrapping from the last index to 0. The pointer then moves to the slot after the victim. After reset the pointer is 0, so slots fill in index order and then evict the oldest.
- R7: A slot written with `fill_wired`=1 is skipped by the victim search and stays valid through any number of later refills.
- R8: A cycle with `flush`=1 clears the valid flag of every non-wired slot at that edge. Wired slots keep hitting.
- R9: While `flush`=1, `fill_ready` is 0 and a presented refill is not taken.
- R10: A refill of a new tag when all slots are wired writes nothing. `fill_drop_err` is 1 for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup presented this cycle |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_off | input | OFF_W | Page offset passed into the physical address |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_miss | output | 1 | Lookup found no match |
| lk_pfn | output | PFN_W | Matched frame number (0 without a hit) |
| lk_paddr | output | PFN_W+OFF_W | {frame, offset} |
| fill_valid | input | 1 | Refill presented |
| fill_ready | output | 1 | Refill can be taken (low during flush) |
| fill_vpn | input | VPN_W | Refill page number |
| fill_asid | input | ASID_W | Refill identifier |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_wired | input | 1 | Mark the slot as wired |
| flush | input | 1 | Invalidate all non-wired slots |
| fill_drop_err | output | 1 | Previous-cycle refill was dropped |

## Verification
The lookup results are combinational, so the bench samples them one time unit after it changes the lookup inputs, at a point halfway between clock edges. A refill or flush is driven at a falling edge and takes effect at the next rising edge. Its effects are therefore checked from the following falling edge onward. `fill_drop_err` is checked at that same falling edge and again one cycle later, where it must be back at 0. `fill_ready` is sampled one unit after `flush` rises, before any edge occurs.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE   = 2'd0,
    FILL_UPDATE = 2'd1,
    FILL_ALLOC  = 2'd2,
    FILL_DROP   = 2'd3
  } fill_kind_e;

  // circular index step: (a + b) mod n, with a, b < n
  function automatic int ring_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/xc_match.sv
module xc_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]             valid_q,
  input  logic [N-1:0][VPN_W-1:0]  vpn_q,
  input  logic [N-1:0][ASID_W-1:0] asid_q,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [ASID_W-1:0]        key_asid,
  output logic [N-1:0]             hit_vec,
  output logic                     any_hit,
  output logic [IDX_W-1:0]         hit_idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (vpn_q[g] == key_vpn) && (asid_q[g] == key_asid);
  end

  assign any_hit = |hit_vec;

  // at most one bit is set, so OR-ing indices is an encoder
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     wired_q,
  input  logic [IDX_W-1:0] ptr_q,
  output logic             vic_found,
  output logic [IDX_W-1:0] vic_idx
);
  import xc_pkg::*;

  always_comb begin
    int pos;
    vic_found = 1'b0;
    vic_idx   = '0;
    for (int k = 0; k < N; k++) begin
      pos = ring_add(int'(ptr_q), k, N);
      if (!vic_found && !wired_q[pos]) begin
        vic_found = 1'b1;
        vic_idx   = IDX_W'(pos);
      end
    end
  end

endmodule

// File: rtl/xc_store.sv
module xc_store #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [ASID_W-1:0]        wr_asid,
  input  logic [PFN_W-1:0]         wr_pfn,
  input  logic                     wr_wired,
  input  logic                     ptr_load,
  input  logic [IDX_W-1:0]         ptr_next,
  output logic [N-1:0]             valid_q,
  output logic [N-1:0]             wired_q,
  output logic [N-1:0][VPN_W-1:0]  vpn_q,
  output logic [N-1:0][ASID_W-1:0] asid_q,
  output logic [N-1:0][PFN_W-1:0]  pfn_q,
  output logic [IDX_W-1:0]         ptr_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      wired_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (flush) begin
        valid_q <= valid_q & wired_q;
      end else if (wr_en) begin
        valid_q[wr_idx] <= 1'b1;
        wired_q[wr_idx] <= wr_wired;
      end
      if (ptr_load) ptr_q <= ptr_next;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_en && !flush && (wr_idx == IDX_W'(i))) begin
        vpn_q[i]  <= wr_vpn;
        asid_q[i] <= wr_asid;
        pfn_q[i]  <= wr_pfn;
      end
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 16,
  parameter int OFF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic [OFF_W-1:0]         lk_off,
  output logic                     lk_hit,
  output logic                     lk_miss,
  output logic [PFN_W-1:0]         lk_pfn,
  output logic [PFN_W+OFF_W-1:0]   lk_paddr,
  input  logic                     fill_valid,
  output logic                     fill_ready,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [ASID_W-1:0]        fill_asid,
  input  logic [PFN_W-1:0]         fill_pfn,
  input  logic                     fill_wired,
  input  logic                     flush,
  output logic                     fill_drop_err
);
  import xc_pkg::*;

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q, wired_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [IDX_W-1:0]               ptr_q, ptr_next;

  logic [ENTRIES-1:0] lk_vec, fm_vec;
  logic               lk_any, fm_any, vic_found;
  logic [IDX_W-1:0]   lk_idx, fm_idx, vic_idx, wr_idx;
  logic               fill_acc, wr_en, ptr_load;
  fill_kind_e         fill_kind;

  // lookup comparator bank
  xc_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
    .valid_q (valid_q), .vpn_q (vpn_q), .asid_q (asid_q),
    .key_vpn (lk_vpn), .key_asid (lk_asid),
    .hit_vec (lk_vec), .any_hit (lk_any), .hit_idx (lk_idx)
  );

  // refill duplicate-detection comparator bank
  xc_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fm_match (
    .valid_q (valid_q), .vpn_q (vpn_q), .asid_q (asid_q),
    .key_vpn (fill_vpn), .key_asid (fill_asid),
    .hit_vec (fm_vec), .any_hit (fm_any), .hit_idx (fm_idx)
  );

  xc_victim #(.N(ENTRIES)) u_victim (
    .wired_q (wired_q), .ptr_q (ptr_q),
    .vic_found (vic_found), .vic_idx (vic_idx)
  );

  assign fill_ready = !flush;
  assign fill_acc   = fill_valid && fill_ready;

  always_comb begin
    fill_kind = FILL_IDLE;
    wr_idx    = fm_idx;
    if (fill_acc) begin
      if (fm_any) begin
        fill_kind = FILL_UPDATE;
      end else if (vic_found) begin
        fill_kind = FILL_ALLOC;
        wr_idx    = vic_idx;
      end else begin
        fill_kind = FILL_DROP;
      end
    end
  end

  assign wr_en    = (fill_kind == FILL_UPDATE) || (fill_kind == FILL_ALLOC);
  assign ptr_load = (fill_kind == FILL_ALLOC);
  assign ptr_next = (vic_idx == IDX_W'(ENTRIES - 1)) ? '0 : vic_idx + 1'b1;

  xc_store #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_store (
    .clk (clk), .rst_n (rst_n), .flush (flush),
    .wr_en (wr_en), .wr_idx (wr_idx),
    .wr_vpn (fill_vpn), .wr_asid (fill_asid), .wr_pfn (fill_pfn), .wr_wired (fill_wired),
    .ptr_load (ptr_load), .ptr_next (ptr_next),
    .valid_q (valid_q), .wired_q (wired_q),
    .vpn_q (vpn_q), .asid_q (asid_q), .pfn_q (pfn_q), .ptr_q (ptr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fill_drop_err <= 1'b0;
    else        fill_drop_err <= (fill_kind == FILL_DROP);
  end

  assign lk_hit   = lk_req && lk_any;
  assign lk_miss  = lk_req && !lk_any;
  assign lk_pfn   = lk_hit ? pfn_q[lk_idx] : '0;
  assign lk_paddr = {lk_pfn, lk_off};

endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         fill_valid,
  input logic         fill_ready,
  input logic         lk_req,
  input logic         lk_hit,
  input logic         lk_miss,
  input logic         fill_drop_err,
  input logic [N-1:0] valid_q,
  input logic [N-1:0] wired_q,
  input logic [N-1:0] lk_vec,
  input logic [N-1:0] fm_vec
);

  // R4
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_miss));

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec) && $onehot0(fm_vec));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & ~wired_q) == '0));

  // R7
  wired_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((valid_q & $past(valid_q & wired_q)) == $past(valid_q & wired_q)));

  // R9
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fill_ready);

  // R10
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_drop_err |-> $past(fill_valid && fill_ready));

endmodule

bind xlat_cache xc_checker #(.N(ENTRIES)) u_chk (
  .clk (clk), .rst_n (rst_n), .flush (flush),
  .fill_valid (fill_valid), .fill_ready (fill_ready),
  .lk_req (lk_req), .lk_hit (lk_hit), .lk_miss (lk_miss),
  .fill_drop_err (fill_drop_err),
  .valid_q (valid_q), .wired_q (wired_q),
  .lk_vec (lk_vec), .fm_vec (fm_vec)
);

// File: tb/xlat_cache_tb.sv
`timescale 1ns/100ps
module xlat_cache_tb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_req;
  logic [19:0] lk_vpn;
  logic [7:0]  lk_asid;
  logic [11:0] lk_off;
  logic lk_hit, lk_miss;
  logic [15:0] lk_pfn;
  logic [27:0] lk_paddr;
  logic fill_valid, fill_ready, fill_wired, flush, fill_drop_err;
  logic [19:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [15:0] fill_pfn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_v[N], m_w[N], m_vpn[N], m_asid[N], m_pfn[N];
  int m_ptr;
  int sv_vpn[N], sv_asid[N];

  always #2.5 clk = ~clk;

  xlat_cache u_dut (
    .clk (clk), .rst_n (rst_n),
    .lk_req (lk_req), .lk_vpn (lk_vpn), .lk_asid (lk_asid), .lk_off (lk_off),
    .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_pfn (lk_pfn), .lk_paddr (lk_paddr),
    .fill_valid (fill_valid), .fill_ready (fill_ready),
    .fill_vpn (fill_vpn), .fill_asid (fill_asid), .fill_pfn (fill_pfn),
    .fill_wired (fill_wired), .flush (flush), .fill_drop_err (fill_drop_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_find(input int vpn, input int asid);
    for (int i = 0; i < N; i++)
      if (m_v[i] != 0 && m_vpn[i] == vpn && m_asid[i] == asid) return i;
    return -1;
  endfunction

  // reference model: returns 1 when the refill is dropped
  function automatic bit m_fill(input int vpn, input int asid, input int pfn, input int w);
    int idx;
    idx = m_find(vpn, asid);
    if (idx >= 0) begin
      m_pfn[idx] = pfn; m_w[idx] = w;
      return 0;
    end
    for (int k = 0; k < N; k++) begin
      idx = (m_ptr + k) % N;
      if (m_w[idx] == 0) begin
        m_v[idx] = 1; m_w[idx] = w; m_vpn[idx] = vpn; m_asid[idx] = asid; m_pfn[idx] = pfn;
        m_ptr = (idx + 1) % N;
        return 0;
      end
    end
    return 1;
  endfunction

  task automatic look(input int vpn, input int asid, input string req);
    logic [29:0] act, exp;
    logic [11:0] off;
    int idx;
    off     = 12'(vpn) ^ 12'hA5C;
    lk_req  = 1'b1;
    lk_vpn  = 20'(vpn);
    lk_asid = 8'(asid);
    lk_off  = off;
    #1;
    idx = m_find(vpn, asid);
    if (idx >= 0) exp = {1'b1, 1'b0, 16'(m_pfn[idx]), off};
    else          exp = {1'b0, 1'b1, 16'h0, off};
    act = {lk_hit, lk_miss, lk_paddr};
    chk(act === exp, req, "lookup {hit,miss,paddr}", longint'(act), longint'(exp));
  endtask

  task automatic look_all(input string req);
    for (int i = 0; i < N; i++) begin
      if (m_v[i] != 0) begin
        look(m_vpn[i], m_asid[i], req);
        look(m_vpn[i], m_asid[i] ^ 1, "R3");
      end
    end
  endtask

  task automatic do_fill(input int vpn, input int asid, input int pfn, input int w,
                         input string req);
    bit drop;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 20'(vpn); fill_asid = 8'(asid);
    fill_pfn = 16'(pfn); fill_wired = w[0];
    drop = m_fill(vpn, asid, pfn, w);
    @(negedge clk);
    fill_valid = 1'b0;
    chk(fill_drop_err === drop, req, "drop flag", longint'(fill_drop_err), longint'(drop));
  endtask

  task automatic do_flush(input bit with_fill, input int vpn);
    @(negedge clk);
    flush = 1'b1;
    if (with_fill) begin
      fill_valid = 1'b1; fill_vpn = 20'(vpn); fill_asid = 8'd0; fill_pfn = 16'h1234; fill_wired = 1'b0;
    end
    #1;
    chk(fill_ready === 1'b0, "R9", "fill_ready during flush", longint'(fill_ready), 0);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    for (int i = 0; i < N; i++) if (m_w[i] == 0) m_v[i] = 0;
    chk(fill_drop_err === 1'b0, "R9", "no drop on flush", longint'(fill_drop_err), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ev_vpn, ev_asid, cnt;
    rst_n = 1'b0; lk_req = 1'b0; lk_vpn = '0; lk_asid = '0; lk_off = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_wired = 1'b0; flush = 1'b0;
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_w[i] = 0; m_vpn[i] = 0; m_asid[i] = 0; m_pfn[i] = 0; end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    for (int v = 0; v < 8; v++) look(v * 5, v % 3, "R1");
    chk(fill_drop_err === 1'b0, "R1", "err after reset", longint'(fill_drop_err), 0);
    chk(fill_ready === 1'b1, "R1", "ready after reset", longint'(fill_ready), 1);

    // R2/R3/R6: fill every slot in order
    for (int i = 0; i < N; i++) begin
      do_fill(i * 37 + 5, i % 3, i * 11 + 300, 0, "R6");
      look(i * 37 + 5, i % 3, "R2");
      look(i * 37 + 5, (i % 3) + 1, "R3");
    end
    look_all("R2");

    // R4: idle lookup
    lk_req = 1'b0; #1;
    chk({lk_hit, lk_miss} === 2'b00, "R4", "idle outputs", longint'({lk_hit, lk_miss}), 0);
    look(99999, 7, "R4");

    // R6: evictions follow the pointer
    for (int j = 0; j < 6; j++) begin
      ev_vpn = m_vpn[m_ptr]; ev_asid = m_asid[m_ptr];
      do_fill(1000 + j, 0, 500 + j, 0, "R6");
      look(ev_vpn, ev_asid, "R6");
      look(1000 + j, 0, "R6");
    end
    look_all("R6");

    // R5: refill of an existing tag
    do_fill(m_vpn[10], m_asid[10], 16'hBEEF, 0, "R5");
    look(m_vpn[10], m_asid[10], "R5");
    ev_vpn = m_vpn[m_ptr]; ev_asid = m_asid[m_ptr];
    do_fill(1500, 2, 777, 0, "R5");
    look(ev_vpn, ev_asid, "R5");
    look_all("R5");

    // R7: wired slots survive replacement
    for (int k = 0; k < 4; k++) do_fill(2000 + k, 1, 900 + k, 1, "R7");
    for (int k = 0; k < 20; k++) do_fill(2500 + k, 3, 1100 + k, 0, "R7");
    for (int k = 0; k < 4; k++) look(2000 + k, 1, "R7");
    look_all("R7");

    // R8: flush
    for (int i = 0; i < N; i++) begin sv_vpn[i] = m_vpn[i]; sv_asid[i] = m_asid[i]; end
    do_flush(1'b0, 0);
    for (int i = 0; i < N; i++) look(sv_vpn[i], sv_asid[i], "R8");

    // R9: refill presented during flush is not taken
    do_flush(1'b1, 3000);
    look(3000, 0, "R9");

    // R10: wire every slot, then a new tag is dropped
    cnt = 0;
    for (int i = 0; i < N; i++) if (m_w[i] != 0) cnt++;
    for (int k = 0; cnt < N; k++) begin
      do_fill(4000 + k, 2, 1300 + k, 1, "R10");
      cnt = 0;
      for (int i = 0; i < N; i++) if (m_w[i] != 0) cnt++;
    end
    do_fill(5000, 0, 1, 0, "R10");
    look(5000, 0, "R10");
    @(negedge clk);
    chk(fill_drop_err === 1'b0, "R10", "err one cycle only", longint'(fill_drop_err), 0);
    do_fill(4000, 2, 42, 1, "R10");
    look(4000, 2, "R10");
    look_all("R10");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule